// File: doc/BRIEF.md
# Cycle Counter with Postscaled Event Generation

The block holds a 32-bit core cycle counter that advances by one on every core cycle while it is enabled and the core is not halted, and wraps from all-ones back to zero. A small register bus reaches two words, a control word and the counter itself. Software can read and load both. The counter serves both as a timebase for measuring elapsed cycles and as the source of periodic events.

One of two low counter bits is chosen as a tap. Every change of that bit, rising or falling, is a tap change. A 4-bit postscaler counts these changes down. When a tap change finds the postscaler at zero, the block fires and reloads the postscaler from a preset. A preset of N therefore fires once every N+1 tap changes. A fired event is routed as follows:
- If PC sampling is enabled, it becomes a one-cycle PC-sample strobe that carries the current program counter.
- Otherwise, if the cycle event is enabled, it becomes a plain cycle-event pulse.
- Otherwise it is dropped.

A separate selector watches one of three high counter bits and emits a synchronisation pulse on each change of that bit. The event routing is a three-way decision with the states RT_OFF, RT_CYC and RT_PCS:
- RT_OFF is taken when nothing fires, or when an event fires with both enables clear.
- RT_CYC is taken when an event fires with only the cycle event enabled.
- RT_PCS is taken when an event fires with PC sampling enabled.

The routing is re-decided every cycle, so there are no held transitions.

Top module: `cyc_evt_top`

## Requirements
- R1: While the enable bit is 1, `cnt_absent` is 0 and `core_halted` is 0, the counter increases by one per clock and wraps from 0xFFFFFFFF to 0. In every other cycle without a load, it holds its value.
- R2: A bus write to address 1 loads `bus_wdata` into the counter. A load takes priority over an increment in the same cycle. Reading address 1 returns the counter value.
- R3: Tap select 0 watches counter bit 6, and tap select 1 watches bit 10. A 0-to-1 change and a 1-to-0 change of the watched bit each count as one tap change.
- R4: On a tap change, a nonzero postscaler decreases by one. A postscaler at zero fires and reloads from the preset, so a preset of N fires on every (N+1)th change.
- R5: When PC sampling is enabled, a firing raises `pcs_strobe` and `cyc_evt` stays low. `cyc_evt` rises on a firing only when PC sampling is disabled and the cycle-event enable is set. The two outputs are never high together.
- R6: `pcs_strobe` is high only in the cycle of the firing. In that cycle `pcs_pc` equals `pc_in`, and at all other times `pcs_pc` is 0.
- R7: Sync select 0 gives no pulses. Select 1, 2 and 3 watch counter bits 24, 26 and 28. Each change of the watched bit gives a one-cycle `sync_pulse`, but only while the effective counter enable and `sync_ext_en` are both 1.
- R8: While `cnt_absent` is 1, the enable bit reads as 0, the counter does not count, and a written enable of 1 is dropped; it stays 0 after `cnt_absent` falls.
- R9: Reading address 0 returns the control word, and a write to it loads every field. A postscaler write takes priority over a tap change in the same cycle. The control word layout is:
  - bit 0: counter enable
  - bits 4:1: preset
  - bits 8:5: postscaler value
  - bit 9: tap select
  - bits 11:10: sync select
  - bit 12: PC-sample enable
  - bit 13: cycle-event enable
  - all other bits: read as 0

  Reset clears the counter, the postscaler, the preset and every enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_halted | input | 1 | Core is halted; counter holds |
| sync_ext_en | input | 1 | External permission for sync pulses |
| cnt_absent | input | 1 | Configuration: counter not present |
| pc_in | input | 32 | Current program counter |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 = control word, 1 = counter |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| cyc_evt | output | 1 | Periodic cycle-event pulse |
| pcs_strobe | output | 1 | PC-sample strobe |
| pcs_pc | output | 32 | PC captured with the strobe |
| sync_pulse | output | 1 | Synchronisation pulse |

## Verification
The postscaler is exercised with several combinations of preset and tap:
- Preset 3 on bit 6 and preset 0 on bit 10 are counted over fixed windows from a known counter value. The event totals separate a correct every-(N+1) reload from an off-by-one, and separate both-edge detection from rising-only detection.
- The same window is rerun with PC sampling enabled, which shows whether the strobe takes priority over the cycle event.

Several counter patterns are also tried:
- Random halt patterns check that the counter stalls exactly when it should.
- Loads just below a 2^24, 2^26 or 2^28 boundary check each sync selection with the external permission on and off.
- A load near the top of the range checks the wrap.
- Toggling the absent input checks that the enable write is dropped.

// File: rtl/cyc_evt_pkg.sv
package cyc_evt_pkg;

    localparam int CNT_W = 32;
    localparam int PS_W  = 4;

    // Control word as seen on the bus (LSB = counter enable).
    typedef struct packed {
        logic            cyc_ev_en;
        logic            pcs_en;
        logic [1:0]      sync_sel;
        logic            tap_sel;
        logic [PS_W-1:0] ps_val;
        logic [PS_W-1:0] preset;
        logic            cnt_en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // Where a fired tap event is sent.
    typedef enum logic [1:0] {
        RT_OFF = 2'd0,
        RT_CYC = 2'd1,
        RT_PCS = 2'd2
    } route_t;

endpackage

// File: rtl/cyc_counter.sv
module cyc_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (inc) begin
            cnt_q <= cnt_q + W'(1);
        end
    end

    assign cnt = cnt_q;

    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load) |=> cnt_q == $past(cnt_q) + W'(1));

    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !load) |=> $stable(cnt_q));

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt_q == $past(load_val));

endmodule

// File: rtl/cyc_postscaler.sv
module cyc_postscaler #(
    parameter int PSW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [1:0]     tap_chg,
    input  logic           tap_sel,
    input  logic [PSW-1:0] preset,
    input  logic           wr_ps,
    input  logic [PSW-1:0] wr_val,
    output logic [PSW-1:0] ps_val,
    output logic           fire
);

    logic [PSW-1:0] ps_q;
    logic           tap_evt;

    assign tap_evt = tap_sel ? tap_chg[1] : tap_chg[0];
    assign fire    = tap_evt && (ps_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps_q <= '0;
        end else if (wr_ps) begin
            ps_q <= wr_val;
        end else if (tap_evt) begin
            if (ps_q == '0) ps_q <= preset;
            else            ps_q <= ps_q - PSW'(1);
        end
    end

    assign ps_val = ps_q;

    p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !wr_ps) |=> ps_q == $past(preset));

    p_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tap_evt && ps_q != '0 && !wr_ps) |=> ps_q == $past(ps_q) - PSW'(1));

    p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tap_evt && !wr_ps) |=> $stable(ps_q));

    p_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ps |=> ps_q == $past(wr_val));

endmodule

// File: rtl/cyc_sync_tap.sv
module cyc_sync_tap (
    input  logic [2:0] sync_chg,
    input  logic [1:0] sync_sel,
    input  logic       gate,
    output logic       pulse
);

    logic [3:0] sel_chg;

    assign sel_chg = {sync_chg, 1'b0};   // select 0 = no sync
    assign pulse   = gate && sel_chg[sync_sel];

endmodule

// File: rtl/cyc_evt_top.sv
module cyc_evt_top
    import cyc_evt_pkg::*;
#(
    parameter int TAP_LO    = 6,
    parameter int TAP_HI    = 10,
    parameter int SYNC_BASE = 24,
    parameter int SYNC_STEP = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             core_halted,
    input  logic             sync_ext_en,
    input  logic             cnt_absent,
    input  logic [CNT_W-1:0] pc_in,
    input  logic             bus_wr,
    input  logic             bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    output logic             cyc_evt,
    output logic             pcs_strobe,
    output logic [CNT_W-1:0] pcs_pc,
    output logic             sync_pulse
);

    localparam int NWATCH = 5;   // 2 tap bits + 3 sync bits

    ctrl_t             wv;
    logic              wr_ctrl, wr_cnt;
    logic              cnt_en_q, tap_sel_q, pcs_en_q, cyc_en_q;
    logic [PS_W-1:0]   preset_q, ps_val;
    logic [1:0]        sync_sel_q;
    logic              en_eff, fire;
    logic [CNT_W-1:0]  cnt;
    logic [NWATCH-1:0] watch, watch_q, chg;
    route_t            route;

    assign wv      = bus_wdata[CTRL_W-1:0];
    assign wr_ctrl = bus_wr && !bus_addr;
    assign wr_cnt  = bus_wr &&  bus_addr;
    assign en_eff  = cnt_en_q && !cnt_absent;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_en_q   <= 1'b0;
            preset_q   <= '0;
            tap_sel_q  <= 1'b0;
            sync_sel_q <= '0;
            pcs_en_q   <= 1'b0;
            cyc_en_q   <= 1'b0;
        end else if (wr_ctrl) begin
            cnt_en_q   <= wv.cnt_en && !cnt_absent;
            preset_q   <= wv.preset;
            tap_sel_q  <= wv.tap_sel;
            sync_sel_q <= wv.sync_sel;
            pcs_en_q   <= wv.pcs_en;
            cyc_en_q   <= wv.cyc_ev_en;
        end
    end

    cyc_counter #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (en_eff && !core_halted),
        .load     (wr_cnt),
        .load_val (bus_wdata),
        .cnt      (cnt)
    );

    // Counter bits whose changes are watched.
    assign watch[0] = cnt[TAP_LO];
    assign watch[1] = cnt[TAP_HI];
    for (genvar i = 0; i < 3; i++) begin : g_sync_watch
        assign watch[2+i] = cnt[SYNC_BASE + i*SYNC_STEP];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) watch_q <= '0;
        else        watch_q <= watch;
    end

    assign chg = watch ^ watch_q;

    cyc_postscaler #(.PSW(PS_W)) u_ps (
        .clk     (clk),
        .rst_n   (rst_n),
        .tap_chg (chg[1:0]),
        .tap_sel (tap_sel_q),
        .preset  (preset_q),
        .wr_ps   (wr_ctrl),
        .wr_val  (wv.ps_val),
        .ps_val  (ps_val),
        .fire    (fire)
    );

    cyc_sync_tap u_sync (
        .sync_chg (chg[4:2]),
        .sync_sel (sync_sel_q),
        .gate     (en_eff && sync_ext_en),
        .pulse    (sync_pulse)
    );

    always_comb begin
        if (!fire)         route = RT_OFF;
        else if (pcs_en_q) route = RT_PCS;
        else if (cyc_en_q) route = RT_CYC;
        else               route = RT_OFF;
    end

    always_comb begin
        cyc_evt    = 1'b0;
        pcs_strobe = 1'b0;
        pcs_pc     = '0;
        unique case (route)
            RT_CYC:  cyc_evt = 1'b1;
            RT_PCS: begin
                pcs_strobe = 1'b1;
                pcs_pc     = pc_in;
            end
            default: ;
        endcase
    end

    always_comb begin
        if (bus_addr) bus_rdata = cnt;
        else bus_rdata = {{(CNT_W-CTRL_W){1'b0}}, cyc_en_q, pcs_en_q, sync_sel_q,
                          tap_sel_q, ps_val, preset_q, en_eff};
    end

    p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(pcs_strobe && cyc_evt));

    p_pcs_prio_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pcs_en_q |-> !cyc_evt);

    p_pc_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !pcs_strobe |-> pcs_pc == '0);

    p_sync_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse |-> (sync_ext_en && !cnt_absent && sync_sel_q != 2'd0));

    p_absent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_absent && !bus_addr) |-> bus_rdata[0] == 1'b0);

    p_absent_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_absent && !wr_cnt) |=> $stable(cnt));

endmodule

// File: tb/sim_cyc_evt_top.sv
module sim_cyc_evt_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        core_halted = 1'b0, sync_ext_en = 1'b0, cnt_absent = 1'b0;
    logic [31:0] pc_in = '0;
    logic        bus_wr = 1'b0, bus_addr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, pcs_pc;
    logic        cyc_evt, pcs_strobe, sync_pulse;

    int checks = 0, failures = 0;
    int n_cyc = 0, n_pcs = 0, n_sync = 0;

    // reference model state
    logic [31:0] m_cnt = '0, m_prev = '0;
    logic [3:0]  m_ps = '0, m_preset = '0;
    logic [1:0]  m_ssel = '0;
    logic        m_en = 0, m_tsel = 0, m_pcs = 0, m_cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cyc_evt_top u0 (
        .clk(clk), .rst_n(rst_n), .core_halted(core_halted), .sync_ext_en(sync_ext_en),
        .cnt_absent(cnt_absent), .pc_in(pc_in), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cyc_evt(cyc_evt),
        .pcs_strobe(pcs_strobe), .pcs_pc(pcs_pc), .sync_pulse(sync_pulse)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] cw(input logic en, input logic [3:0] pre, input logic [3:0] ps,
                                       input logic ts, input logic [1:0] ss, input logic pcs,
                                       input logic cyc);
        return {18'b0, cyc, pcs, ss, ts, ps, pre, en};
    endfunction

    // One clock: compare outputs with the model, then advance the model.
    task automatic tick();
        int          tb, sb;
        logic        tev, fire, e_cyc, e_str, e_sync;
        logic [31:0] e_pc, e_rd, nc;
        #2;
        tb   = m_tsel ? 10 : 6;
        tev  = m_cnt[tb] != m_prev[tb];
        fire = tev && (m_ps == 0);
        e_cyc = fire && !m_pcs && m_cyc;
        e_str = fire && m_pcs;
        e_pc  = e_str ? pc_in : 32'h0;
        sb    = 22 + 2 * int'(m_ssel);
        e_sync = (m_ssel != 0) && m_en && !cnt_absent && sync_ext_en && (m_cnt[sb] != m_prev[sb]);
        e_rd  = bus_addr ? m_cnt : cw(m_en && !cnt_absent, m_preset, m_ps, m_tsel, m_ssel, m_pcs, m_cyc);
        check("R4 R5 cyc_evt", {31'b0, cyc_evt}, {31'b0, e_cyc});
        check("R5 pcs_strobe", {31'b0, pcs_strobe}, {31'b0, e_str});
        check("R6 pcs_pc", pcs_pc, e_pc);
        check("R7 sync_pulse", {31'b0, sync_pulse}, {31'b0, e_sync});
        check(bus_addr ? "R1 R2 counter read" : "R9 control read", bus_rdata, e_rd);
        n_cyc  += int'(cyc_evt);
        n_pcs  += int'(pcs_strobe);
        n_sync += int'(sync_pulse);
        nc = m_cnt;
        if (bus_wr && bus_addr) nc = bus_wdata;
        else if (m_en && !cnt_absent && !core_halted) nc = m_cnt + 32'd1;
        if (bus_wr && !bus_addr) begin
            m_ps     = bus_wdata[8:5];
            m_preset = bus_wdata[4:1];
            m_tsel   = bus_wdata[9];
            m_ssel   = bus_wdata[11:10];
            m_pcs    = bus_wdata[12];
            m_cyc    = bus_wdata[13];
            m_en     = bus_wdata[0] && !cnt_absent;
        end else if (tev) begin
            m_ps = (m_ps == 0) ? m_preset : m_ps - 4'd1;
        end
        m_prev = m_cnt;
        m_cnt  = nc;
        @(negedge clk);
        pc_in = pc_in + 32'h0000_0104;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr(input logic a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 1'b0; bus_addr = 1'b1;
    endtask

    // stop counter, zero it, let the change history settle
    task automatic restart(input logic [31:0] ctrl_on);
        wr(1'b0, 32'h0);
        wr(1'b1, 32'h0);
        idle(2);
        wr(1'b0, ctrl_on);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int c0, p0, s0;
        logic [31:0] v;
        repeat (3) @(negedge clk);
        // R9 reset state
        bus_addr = 1'b0; #1;
        check("R9 reset control", bus_rdata, 32'h0);
        bus_addr = 1'b1; #1;
        check("R1 reset counter", bus_rdata, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        idle(3);

        // R4: preset 3 on bit 6 -> 11 changes, fires 1st/5th/9th
        restart(cw(1, 4'd3, 4'd0, 0, 2'd0, 0, 1));
        c0 = n_cyc;
        idle(760);
        check("R4 preset 3 event count", n_cyc - c0, 3);

        // R5: PC sampling takes priority
        restart(cw(1, 4'd3, 4'd0, 0, 2'd0, 1, 1));
        c0 = n_cyc; p0 = n_pcs;
        idle(760);
        check("R5 strobe count", n_pcs - p0, 3);
        check("R5 cycle event suppressed", n_cyc - c0, 0);

        // R3: tap on bit 10, preset 0, both edges
        restart(cw(1, 4'd0, 4'd0, 1, 2'd0, 0, 1));
        c0 = n_cyc;
        idle(2100);
        check("R3 bit10 both edges", n_cyc - c0, 2);

        // R1: halted patterns
        restart(cw(1, 4'd1, 4'd0, 0, 2'd0, 1, 0));
        for (int i = 0; i < 600; i++) begin
            core_halted = ($urandom % 3) == 0;
            tick();
        end
        core_halted = 1'b0;

        // R1 wrap
        wr(1'b1, 32'hFFFF_FFFE);
        idle(2);
        bus_addr = 1'b1; #1;
        check("R1 wrap to zero", bus_rdata, 32'h0);
        idle(1);

        // R2 load beats increment
        wr(1'b1, 32'h0000_1234);
        #1;
        check("R2 load wins", bus_rdata, 32'h0000_1234);
        idle(1);

        // R7 sync selections
        wr(1'b0, cw(1, 4'd0, 4'd0, 0, 2'd1, 0, 0));
        sync_ext_en = 1'b1;
        s0 = n_sync;
        wr(1'b1, 32'h00FF_FFF0);
        idle(40);
        check("R7 bit24 sync", n_sync - s0, 1);
        wr(1'b0, cw(1, 4'd0, 4'd0, 0, 2'd2, 0, 0));
        s0 = n_sync;
        wr(1'b1, 32'h03FF_FFF0);
        idle(40);
        check("R7 bit26 sync", n_sync - s0, 1);
        wr(1'b0, cw(1, 4'd0, 4'd0, 0, 2'd3, 0, 0));
        s0 = n_sync;
        wr(1'b1, 32'h0FFF_FFF0);
        idle(40);
        check("R7 bit28 sync", n_sync - s0, 1);
        sync_ext_en = 1'b0;
        wr(1'b0, cw(1, 4'd0, 4'd0, 0, 2'd1, 0, 0));
        s0 = n_sync;
        wr(1'b1, 32'h00FF_FFF0);
        idle(40);
        check("R7 ext disable", n_sync - s0, 0);
        sync_ext_en = 1'b1;
        wr(1'b0, cw(1, 4'd0, 4'd0, 0, 2'd0, 0, 0));
        s0 = n_sync;
        wr(1'b1, 32'h00FF_FFF0);
        idle(40);
        check("R7 select zero", n_sync - s0, 0);

        // R9 postscaler write/read
        wr(1'b0, cw(0, 4'd7, 4'd5, 1, 2'd2, 1, 1));
        bus_addr = 1'b0; #1;
        check("R9 control readback", bus_rdata, cw(0, 4'd7, 4'd5, 1, 2'd2, 1, 1));
        idle(2);

        // R8 absent counter
        cnt_absent = 1'b1;
        wr(1'b0, cw(1, 4'd0, 4'd0, 0, 2'd0, 0, 1));
        bus_addr = 1'b0; #1;
        check("R8 enable reads zero", {31'b0, bus_rdata[0]}, 32'h0);
        bus_addr = 1'b1; #1;
        v = bus_rdata;
        idle(5);
        #1;
        check("R8 counter frozen", bus_rdata, v);
        cnt_absent = 1'b0;
        bus_addr = 1'b0; #1;
        check("R8 write stays dropped", {31'b0, bus_rdata[0]}, 32'h0);
        idle(3);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule